// File: doc/BRIEF.md
# Stop-on-Trigger Circular Sample Recorder

This block records a parallel word of sampled channels into an on-chip ring memory. An arm pulse starts recording. From then on, every sample that is both strobed and qualified goes into the next slot of the ring. When the ring is full, each new sample replaces the oldest one. Samples that are not qualified are dropped, so the memory holds only the selected data.

A trigger pulse does not start recording. It marks the point where recording will stop. After the trigger, a programmable number of further qualified samples is stored, and then the block freezes. The ring slot of the trigger sample is latched so that readout can align to it. Each stored word carries a timestamp: the number of clocks since arming. This keeps sparse qualified data correlated in time. The arm input can be driven by another recorder's trigger logic, so several recorders can be chained.

After the block freezes, a read port returns stored entries by age. Index 0 is the oldest. A wrapped flag tells software how much of the ring holds valid data.

Top module: `ring_capture`

## Requirements
- R1: An `arm` pulse sampled at a clock edge makes `capturing` 1, and `done` and `wrapped` 0, from that edge on. It also resets the write slot to 0 and the timestamp counter to 0 for the first cycle after that edge. `arm` has priority over every other input in its cycle.
- R2: While `capturing` is 1, a sample is stored only in a cycle where `sample_en` and `qualify` are both 1. The sample goes into the next ring slot, and at most one sample is stored per clock.
- R3: After DEPTH stores, `wrapped` becomes 1 and stays 1 until the next arm. Later stores overwrite the oldest slot.
- R4: A trigger taken while recording and not yet triggered latches `trig_addr`. The latched value is the ring slot that the trigger cycle's sample uses: the write slot of that cycle.
- R5: If `post_count` is N>0 at the trigger cycle, exactly N further qualified samples are stored after the trigger cycle. `done` becomes 1 (and `capturing` 0) at the edge that stores the Nth one. A qualified sample in the trigger cycle itself is stored but not counted.
- R6: If `post_count` is 0, `done` is 1 from the trigger edge. The trigger cycle's sample is stored only if it was qualified.
- R7: `trig` is ignored before arming, during the post-trigger phase, and after `done`: `trig_addr` and `done` do not change.
- R8: While `done` is 1, nothing is written. Further samples leave the stored contents unchanged.
- R9: `rd_en` with index k gives `rd_valid` one clock later. `rd_data` then holds the k-th oldest entry. Its slot is (write slot + k) mod DEPTH when `wrapped` is 1, and k otherwise.
- R10: Each stored entry's `rd_stamp` equals the number of clocks between the arming edge and its store edge, minus one. The first cycle after arming stamps 0.
- R11: After reset, `done`, `capturing`, `wrapped`, `rd_valid` and `trig_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart recording |
| sample_en | input | 1 | A sample is present this clock |
| sample_data | input | DATA_W | Channel word |
| qualify | input | 1 | Keep this sample |
| trig | input | 1 | Trigger event |
| post_count | input | POST_W | Qualified samples to keep after the trigger |
| capturing | output | 1 | Recording, before or after the trigger |
| done | output | 1 | Frozen |
| wrapped | output | 1 | Ring has filled at least once |
| trig_addr | output | $clog2(DEPTH) | Ring slot of the trigger sample |
| rd_en | input | 1 | Read request |
| rd_idx | input | $clog2(DEPTH) | Age index, 0 = oldest |
| rd_valid | output | 1 | Read result present |
| rd_data | output | DATA_W | Stored channel word |
| rd_stamp | output | TS_W | Stored timestamp |

## Verification
A write slot that moves wrongly shows up as soon as the ring is read back. Entries appear in the wrong age order, or with a `rd_stamp` that does not match the clocks counted from arming. A wrong post-trigger count or a wrong freeze condition shows at `done` in the very cycle the Nth qualified sample should close the capture. Late writes after freezing show up as overwritten oldest entries at readout. A trigger that is not properly ignored changes `trig_addr` one clock after the stray pulse.

// File: rtl/ring_capture_pkg.sv
package ring_capture_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_RUN  = 2'd1,
      CAP_POST = 2'd2,
      CAP_DONE = 2'd3
   } cap_state_t;
endpackage

// File: rtl/ring_capture_ctrl.sv
module ring_capture_ctrl
   import ring_capture_pkg::*;
#(
   parameter int POST_W = 8,
   parameter int AW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              trig,
   input  logic              sample_en,
   input  logic              qualify,
   input  logic [POST_W-1:0] post_count,
   input  logic [AW-1:0]     wr_ptr,
   output cap_state_t        state,
   output logic              store,
   output logic [AW-1:0]     trig_addr
);
   logic [POST_W-1:0] remain;
   logic              active;

   always_comb begin
      active = (state == CAP_RUN) || (state == CAP_POST);
      store  = active && !arm && sample_en && qualify;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CAP_IDLE;
         remain    <= '0;
         trig_addr <= '0;
      end else if (arm) begin
         state  <= CAP_RUN;
         remain <= '0;
      end else begin
         case (state)
            CAP_RUN: begin
               if (trig) begin
                  trig_addr <= wr_ptr;
                  if (post_count == '0) begin
                     state <= CAP_DONE;
                  end else begin
                     remain <= post_count;
                     state  <= CAP_POST;
                  end
               end
            end
            CAP_POST: begin
               if (store) begin
                  remain <= remain - POST_W'(1);
                  if (remain == POST_W'(1)) state <= CAP_DONE;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ring_capture_ptr.sv
module ring_capture_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          store,
   output logic [AW-1:0] wr_ptr,
   output logic          wrapped
);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wr_ptr  <= '0;
         wrapped <= 1'b0;
      end else if (store) begin
         wr_ptr <= wr_ptr + AW'(1);
         if (wr_ptr == LAST_SLOT) wrapped <= 1'b1;
      end
   end
endmodule

// File: rtl/ring_capture_stamp.sv
module ring_capture_stamp #(
   parameter int TS_W     = 16,
   parameter bit STAMP_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   output logic [TS_W-1:0] stamp
);
   generate
      if (STAMP_EN) begin : g_count
         logic [TS_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) cnt <= '0;
            else                 cnt <= cnt + TS_W'(1);
         end
         assign stamp = cnt;
      end else begin : g_none
         assign stamp = '0;
      end
   endgenerate
endmodule

// File: rtl/ring_capture_mem.sv
module ring_capture_mem #(
   parameter int DEPTH   = 16,
   parameter int AW      = 4,
   parameter int WORD_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic              rvalid,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store_q[waddr] <= wdata;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [WORD_W-1:0] rd_q;
         logic              rv_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rv_q <= 1'b0;
            else        rv_q <= re;
            if (re) rd_q <= store_q[raddr];
         end
         assign rvalid = rv_q;
         assign rdata  = rd_q;
      end else begin : g_comb
         assign rvalid = re;
         assign rdata  = store_q[raddr];
      end
   endgenerate
endmodule

// File: rtl/ring_capture.sv
module ring_capture
   import ring_capture_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 16,
   parameter int TS_W     = 16,
   parameter int POST_W   = 8,
   parameter bit STAMP_EN = 1'b1,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic                     sample_en,
   input  logic [DATA_W-1:0]        sample_data,
   input  logic                     qualify,
   input  logic                     trig,
   input  logic [POST_W-1:0]        post_count,
   output logic                     capturing,
   output logic                     done,
   output logic                     wrapped,
   output logic [$clog2(DEPTH)-1:0] trig_addr,
   input  logic                     rd_en,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   output logic [TS_W-1:0]          rd_stamp
);
   localparam int AW     = $clog2(DEPTH);
   localparam int WORD_W = DATA_W + TS_W;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $fatal(1, "ring_capture: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1 || TS_W < 1 || POST_W < 1) begin : g_bad_width
         $fatal(1, "ring_capture: widths must be positive");
      end
   endgenerate

   cap_state_t        state;
   logic              store;
   logic              in_run;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_addr;
   logic [TS_W-1:0]   stamp;
   logic [WORD_W-1:0] rd_word;

   ring_capture_ctrl #(.POST_W(POST_W), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
      .sample_en(sample_en), .qualify(qualify), .post_count(post_count),
      .wr_ptr(wr_ptr), .state(state), .store(store), .trig_addr(trig_addr)
   );

   ring_capture_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clear(arm), .store(store),
      .wr_ptr(wr_ptr), .wrapped(wrapped)
   );

   ring_capture_stamp #(.TS_W(TS_W), .STAMP_EN(STAMP_EN)) u_stamp (
      .clk(clk), .rst_n(rst_n), .clear(arm), .stamp(stamp)
   );

   always_comb begin
      in_run    = (state == CAP_RUN);
      capturing = (state == CAP_RUN) || (state == CAP_POST);
      done      = (state == CAP_DONE);
      rd_addr   = (wrapped ? wr_ptr : '0) + rd_idx;
   end

   ring_capture_mem #(.DEPTH(DEPTH), .AW(AW), .WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(store), .waddr(wr_ptr),
      .wdata({stamp, sample_data}), .re(rd_en), .raddr(rd_addr),
      .rvalid(rd_valid), .rdata(rd_word)
   );

   assign rd_data  = rd_word[DATA_W-1:0];
   assign rd_stamp = rd_word[WORD_W-1:DATA_W];
endmodule

// File: rtl/ring_capture_chk.sv
module ring_capture_chk #(
   parameter int AW      = 4,
   parameter bit OUT_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic          trig,
   input logic          sample_en,
   input logic          qualify,
   input logic          capturing,
   input logic          done,
   input logic          wrapped,
   input logic          in_run,
   input logic [AW-1:0] wr_ptr,
   input logic [AW-1:0] trig_addr,
   input logic          rd_en,
   input logic          rd_valid
);
   assert_arm_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (capturing && !done && !wrapped && wr_ptr == '0));

   assert_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !(sample_en && qualify)) |=> $stable(wr_ptr));

   assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && capturing && sample_en && qualify) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));

   assert_wrap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped && !arm) |=> wrapped);

   assert_trig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !(in_run && trig)) |=> $stable(trig_addr));

   assert_done_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> (done && $stable(wr_ptr)));

   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && capturing));

   generate
      if (OUT_REG) begin : g_rd
         assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> rd_valid);
         assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> !rd_valid);
      end
   endgenerate
endmodule

bind ring_capture ring_capture_chk #(.AW(AW), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .sample_en(sample_en),
   .qualify(qualify), .capturing(capturing), .done(done), .wrapped(wrapped),
   .in_run(in_run), .wr_ptr(wr_ptr), .trig_addr(trig_addr),
   .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/ring_capture_test.sv
module ring_capture_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0, sample_en = 1'b0, qualify = 1'b0, trig = 1'b0;
   logic [15:0] sample_data = '0;
   logic [7:0]  post_count = '0;
   logic        capturing, done, wrapped, rd_en = 1'b0, rd_valid;
   logic [AW-1:0] trig_addr, rd_idx = '0;
   logic [15:0] rd_data, rd_stamp;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // model of expectations, built from the requirements
   int          m_state = 0;   // 0 idle, 1 run, 2 post, 3 done
   int          m_rem = 0, m_wr = 0, m_taddr = 0;
   bit          m_wrap = 0;
   logic [15:0] m_ts = '0;
   logic [15:0] exp_data [DEPTH];
   logic [15:0] exp_ts [DEPTH];
   logic [31:0] sb_q [$];

   ring_capture uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en),
      .sample_data(sample_data), .qualify(qualify), .trig(trig),
      .post_count(post_count), .capturing(capturing), .done(done),
      .wrapped(wrapped), .trig_addr(trig_addr), .rd_en(rd_en),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_stamp(rd_stamp)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic status(input string tag);
      chk({tag, " done"}, 32'(done), 32'(m_state == 3));
      chk({tag, " capturing"}, 32'(capturing), 32'(m_state == 1 || m_state == 2));
      chk({tag, " wrapped"}, 32'(wrapped), 32'(m_wrap));
      chk({tag, " trig_addr"}, 32'(trig_addr), 32'(m_taddr));
   endtask

   task automatic tick(input bit a, input bit en, input bit q, input bit tr, input logic [15:0] d);
      bit st;
      arm = a; sample_en = en; qualify = q; trig = tr; sample_data = d;
      @(posedge clk);
      st = (m_state == 1 || m_state == 2) && !a && en && q;
      if (a) begin
         m_state = 1; m_wr = 0; m_wrap = 0; m_ts = '0; m_rem = 0;
      end else begin
         if (st) begin exp_data[m_wr] = d; exp_ts[m_wr] = m_ts; end
         if (m_state == 1 && tr) begin
            m_taddr = m_wr;
            if (post_count == 0) m_state = 3;
            else begin m_rem = int'(post_count); m_state = 2; end
         end else if (m_state == 2 && st) begin
            m_rem--;
            if (m_rem == 0) m_state = 3;
         end
         if (st) begin
            if (m_wr == DEPTH - 1) m_wrap = 1;
            m_wr = (m_wr + 1) % DEPTH;
         end
         m_ts = m_ts + 16'd1;
      end
      @(negedge clk);
      arm = 0; sample_en = 0; qualify = 0; trig = 0;
   endtask

   // driver: pushes the expected k-th oldest entries, then requests them
   task automatic read_oldest(input int n);
      int base;
      base = m_wrap ? m_wr : 0;
      for (int k = 0; k < n; k++) begin
         sb_q.push_back({exp_ts[(base + k) % DEPTH], exp_data[(base + k) % DEPTH]});
         rd_en = 1'b1; rd_idx = AW'(k);
         @(posedge clk); m_ts = m_ts + 16'd1;
         @(negedge clk);
      end
      rd_en = 1'b0;
      repeat (2) begin @(posedge clk); m_ts = m_ts + 16'd1; @(negedge clk); end
      chk("R9 all reads returned", 32'(sb_q.size()), 32'd0);
   endtask

   // monitor: pops and compares read results
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) begin
            chk("R9 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            logic [31:0] e;
            e = sb_q.pop_front();
            chk("R9 R2 rd_data", 32'(rd_data), 32'(e[15:0]));
            chk("R10 rd_stamp", 32'(rd_stamp), 32'(e[31:16]));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 done", 32'(done), 32'd0);
      chk("R11 capturing", 32'(capturing), 32'd0);
      chk("R11 wrapped", 32'(wrapped), 32'd0);
      chk("R11 trig_addr", 32'(trig_addr), 32'd0);
      chk("R11 rd_valid", 32'(rd_valid), 32'd0);

      // R7 trigger before arm is ignored
      post_count = 8'd0;
      tick(0, 1, 1, 1, 16'h0055);
      chk("R7 pre-arm done", 32'(done), 32'd0);
      chk("R7 pre-arm capturing", 32'(capturing), 32'd0);

      // Phase B: post count 3, not wrapped
      post_count = 8'd3;
      tick(1, 1, 1, 1, 16'h0066);
      status("R1 arm");
      for (int i = 0; i < 10; i++) tick(0, 1, (i % 2) == 0, 0, 16'h0100 + 16'(i));
      tick(0, 0, 1, 0, 16'h0777);   // strobe low: not stored (R2)
      chk("R3 not yet wrapped", 32'(wrapped), 32'd0);
      tick(0, 1, 1, 1, 16'h01AA);
      chk("R4 trig_addr", 32'(trig_addr), 32'd5);
      status("R4 after trigger");
      tick(0, 1, 0, 0, 16'h0888);
      tick(0, 1, 1, 1, 16'h0200);   // trigger during post phase
      chk("R7 post-phase trig_addr", 32'(trig_addr), 32'd5);
      tick(0, 1, 1, 0, 16'h0201);
      chk("R5 not done before last", 32'(done), 32'd0);
      tick(0, 1, 1, 0, 16'h0202);
      chk("R5 done after third", 32'(done), 32'd1);
      chk("R5 capturing low", 32'(capturing), 32'd0);
      for (int i = 0; i < 3; i++) tick(0, 1, 1, 1, 16'h0300 + 16'(i));
      chk("R7 R8 done holds", 32'(done), 32'd1);
      chk("R7 done trig_addr", 32'(trig_addr), 32'd5);
      read_oldest(9);

      // Phase C: wrap, post count 0 with a stored trigger sample
      post_count = 8'd0;
      tick(1, 0, 0, 0, 16'h0);
      chk("R1 rearm done", 32'(done), 32'd0);
      chk("R1 rearm wrapped", 32'(wrapped), 32'd0);
      for (int i = 0; i < 40; i++) tick(0, (i % 7) != 3, 1, 0, 16'h0400 + 16'(i));
      chk("R3 wrapped", 32'(wrapped), 32'd1);
      tick(0, 1, 1, 1, 16'h05EE);
      chk("R6 done at once", 32'(done), 32'd1);
      chk("R6 trig_addr", 32'(trig_addr), 32'd2);
      tick(0, 1, 1, 1, 16'h0600);
      tick(0, 1, 1, 1, 16'h0601);
      status("R8 frozen");
      read_oldest(DEPTH);

      // Phase D: post count 0, trigger with no stored sample
      tick(1, 0, 0, 0, 16'h0);
      for (int i = 0; i < 3; i++) tick(0, 1, 1, 0, 16'h0700 + 16'(i));
      tick(0, 0, 0, 1, 16'h07FF);
      chk("R6 unqualified trigger done", 32'(done), 32'd1);
      chk("R6 unqualified trig_addr", 32'(trig_addr), 32'd3);
      chk("R1 rearm cleared wrap", 32'(wrapped), 32'd0);
      read_oldest(3);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule